// File: doc/BRIEF.md
# Shift-Handshake FIFO with Combined Band Flags

This block is a first-in first-out buffer of 64 words of 9 bits. A producer offers a word with a one-cycle shift-in strobe, and the word is taken only while the input-ready output is high. A consumer always sees the oldest stored word on the data output. It takes that word with a one-cycle shift-out strobe, which is honoured only while output-ready is high. Both strobes are sampled on the rising edge of a single clock.

Two occupancy flags come from the stored-word count. The edge flag is high near either end of the range: almost empty or almost full. The half flag is high from half depth upward. An active-high master reset empties the buffer. An output-enable input forces the data output to zero when it is low.

The handshake lets stages be chained for depth. The upstream output-ready drives the downstream shift-in, the downstream input-ready drives the upstream shift-out, and the upstream data output feeds the downstream data input. For width, stages sit side by side with their ready outputs ANDed.

Top module: `shfifo`

## Requirements
- R1: Words leave in the order they entered, 9 bits each, with up to 64 words held.
- R2: A shift-in strobe stores `dataIn` only while `inReady` is high. A strobe while 64 words are held changes neither the contents nor the flags.
- R3: A shift-out strobe removes the oldest word only while `outReady` is high. A strobe while the buffer is empty is ignored.
- R4: `inReady` is high exactly when fewer than 64 words are held. `outReady` is high exactly when at least one word is held.
- R5: `edgeFlag` is high when 0 to 8 or 56 to 64 words are held, and low for 9 to 55.
- R6: `halfFlag` is high when 32 to 64 words are held, and low for 0 to 31.
- R7: While `masterReset` is high the buffer is emptied. Afterwards `inReady`=1, `outReady`=0, `edgeFlag`=1, `halfFlag`=0 and `dataOut`=0.
- R8: With `outputEnable` low, `dataOut` is all zeros. With it high and data held, `dataOut` shows the oldest word and keeps it until a shift-out is accepted.
- R9: Shift-in and shift-out in the same cycle, with the buffer neither empty nor full, both take effect and the count is unchanged. When full only the shift-out acts. When empty only the shift-in acts.
- R10: While the buffer is empty, `dataOut` is all zeros.
- R11: Two instances chained as described pass words through in order and hold 128 words together.
- R12: Ready and flag outputs change at the clock edge that samples the strobe, not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| masterReset | input | 1 | Active-high asynchronous reset, empties the buffer |
| shiftIn | input | 1 | One-cycle write strobe |
| dataIn | input | 9 | Word to store |
| inReady | output | 1 | High while space remains |
| shiftOut | input | 1 | One-cycle read strobe |
| outReady | output | 1 | High while a word is held |
| dataOut | output | 9 | Oldest word, or zero when empty or disabled |
| outputEnable | input | 1 | Low forces `dataOut` to zero |
| edgeFlag | output | 1 | Almost-empty or almost-full band indicator |
| halfFlag | output | 1 | Half-full indicator |

## Verification
The bench builds the block with its default depth of 64 and width of 9, so every band edge of both flags (8/9, 31/32, 55/56) is reached by a single fill and drain. It also builds a second pair of default instances chained for depth. Pushing 100 words into that pair overfills the first stage into the second, which shows the cascade wiring and the full-stage stall. Simultaneous strobes are applied at empty, full and mid occupancy.

// File: rtl/shfifo_pkg.sv
package shfifo_pkg;
  typedef struct packed {
    logic wrEn;
    logic showWord;
  } ctrlStrobes_t;
endpackage

// File: rtl/shfifo_ctrl.sv
module shfifo_ctrl
  import shfifo_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int LOW_BAND   = 8,
  parameter int HIGH_BAND  = 56,
  parameter int HALF_MARK  = 32,
  localparam int PTR_W     = $clog2(DEPTH),
  localparam int CNT_W     = PTR_W + 1
) (
  input  logic             clk,
  input  logic             masterReset,
  input  logic             shiftIn,
  input  logic             shiftOut,
  output ctrlStrobes_t     strobes,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic [CNT_W-1:0] occupancy,
  output logic             inReady,
  output logic             outReady,
  output logic             edgeFlag,
  output logic             halfFlag
);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] LOW_CNT   = CNT_W'(LOW_BAND);
  localparam logic [CNT_W-1:0] HIGH_CNT  = CNT_W'(HIGH_BAND);
  localparam logic [CNT_W-1:0] HALF_CNT  = CNT_W'(HALF_MARK);
  localparam logic [PTR_W-1:0] LAST_PTR  = PTR_W'(DEPTH - 1);

  logic             wrEn;
  logic             rdEn;
  logic [CNT_W-1:0] countNext;
  logic             isFull;
  logic             isEmpty;

  function automatic logic [PTR_W-1:0] bumpPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    isFull  = (occupancy == FULL_CNT);
    isEmpty = (occupancy == '0);
    wrEn    = shiftIn  && !isFull;
    rdEn    = shiftOut && !isEmpty;
    countNext = occupancy;
    if (wrEn && !rdEn) countNext = occupancy + 1'b1;
    else if (rdEn && !wrEn) countNext = occupancy - 1'b1;
  end

  always_ff @(posedge clk or posedge masterReset) begin
    if (masterReset) begin
      occupancy <= '0;
      wrPtr     <= '0;
      rdPtr     <= '0;
      inReady   <= 1'b1;
      outReady  <= 1'b0;
      edgeFlag  <= 1'b1;
      halfFlag  <= 1'b0;
    end else begin
      occupancy <= countNext;
      if (wrEn) wrPtr <= bumpPtr(wrPtr);
      if (rdEn) rdPtr <= bumpPtr(rdPtr);
      inReady   <= (countNext != FULL_CNT);
      outReady  <= (countNext != '0);
      edgeFlag  <= (countNext <= LOW_CNT) || (countNext >= HIGH_CNT);
      halfFlag  <= (countNext >= HALF_CNT);
    end
  end

  always_comb begin
    strobes.wrEn     = wrEn;
    strobes.showWord = !isEmpty;
  end
endmodule

// File: rtl/shfifo_datapath.sv
module shfifo_datapath
  import shfifo_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int WIDTH  = 9,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  ctrlStrobes_t     strobes,
  input  logic [PTR_W-1:0] wrPtr,
  input  logic [PTR_W-1:0] rdPtr,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             outputEnable,
  output logic [WIDTH-1:0] dataOut
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (strobes.wrEn) store[wrPtr] <= dataIn;
  end

  always_comb begin
    dataOut = '0;
    if (outputEnable && strobes.showWord) dataOut = store[rdPtr];
  end
endmodule

// File: rtl/shfifo.sv
module shfifo
  import shfifo_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int WIDTH     = 9,
  parameter int LOW_BAND  = 8,
  parameter int HIGH_BAND = 56,
  parameter int HALF_MARK = 32,
  localparam int PTR_W    = $clog2(DEPTH),
  localparam int CNT_W    = PTR_W + 1
) (
  input  logic             clk,
  input  logic             masterReset,
  input  logic             shiftIn,
  input  logic [WIDTH-1:0] dataIn,
  output logic             inReady,
  input  logic             shiftOut,
  output logic             outReady,
  output logic [WIDTH-1:0] dataOut,
  input  logic             outputEnable,
  output logic             edgeFlag,
  output logic             halfFlag
);
  ctrlStrobes_t     strobes;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [CNT_W-1:0] occupancy;

  shfifo_ctrl #(
    .DEPTH(DEPTH), .LOW_BAND(LOW_BAND), .HIGH_BAND(HIGH_BAND), .HALF_MARK(HALF_MARK)
  ) u_ctrl (
    .clk(clk), .masterReset(masterReset), .shiftIn(shiftIn), .shiftOut(shiftOut),
    .strobes(strobes), .wrPtr(wrPtr), .rdPtr(rdPtr), .occupancy(occupancy),
    .inReady(inReady), .outReady(outReady), .edgeFlag(edgeFlag), .halfFlag(halfFlag)
  );

  shfifo_datapath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_data (
    .clk(clk), .strobes(strobes), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .dataIn(dataIn), .outputEnable(outputEnable), .dataOut(dataOut)
  );
endmodule

// File: rtl/shfifo_checker.sv
module shfifo_checker #(
  parameter int DEPTH  = 64,
  parameter int WIDTH  = 9,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             masterReset,
  input logic             shiftIn,
  input logic             shiftOut,
  input logic             inReady,
  input logic             outReady,
  input logic             outputEnable,
  input logic             edgeFlag,
  input logic             halfFlag,
  input logic [WIDTH-1:0] dataOut,
  input logic [CNT_W-1:0] occupancy
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (masterReset)
    occupancy <= CNT_W'(DEPTH)); // R4
  AST_FULL_IGNORES_WRITE: assert property (@(posedge clk) disable iff (masterReset)
    (!inReady && shiftIn && !shiftOut) |=> ($stable(occupancy) && !inReady)); // R2
  AST_EMPTY_IGNORES_READ: assert property (@(posedge clk) disable iff (masterReset)
    (!outReady && shiftOut && !shiftIn) |=> (!outReady && occupancy == '0)); // R3
  AST_BOTH_KEEPS_COUNT: assert property (@(posedge clk) disable iff (masterReset)
    (inReady && outReady && shiftIn && shiftOut) |=> $stable(occupancy)); // R9
  AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (masterReset)
    !outputEnable |-> dataOut == '0); // R8
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (masterReset)
    !outReady |-> dataOut == '0); // R10
  AST_MID_BAND_NONEMPTY: assert property (@(posedge clk) disable iff (masterReset)
    (!edgeFlag && !halfFlag) |-> (outReady && inReady)); // R5
  AST_HALF_NONEMPTY: assert property (@(posedge clk) disable iff (masterReset)
    halfFlag |-> outReady); // R6
endmodule

bind shfifo shfifo_checker #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .masterReset(masterReset), .shiftIn(shiftIn), .shiftOut(shiftOut),
  .inReady(inReady), .outReady(outReady), .outputEnable(outputEnable),
  .edgeFlag(edgeFlag), .halfFlag(halfFlag), .dataOut(dataOut), .occupancy(occupancy)
);

// File: tb/shfifo_bench.sv
`timescale 1ns/1ps
module shfifo_bench;
  localparam int DEPTH = 64;
  localparam int WIDTH = 9;
  localparam int NVEC  = 12;
  // each vector: {shiftIn, shiftOut, dataIn}
  localparam logic [10:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 9'h0A5}, {1'b1, 1'b0, 9'h13C}, {1'b1, 1'b0, 9'h0FF},
    {1'b0, 1'b1, 9'h000}, {1'b1, 1'b1, 9'h101}, {1'b1, 1'b1, 9'h055},
    {1'b0, 1'b1, 9'h000}, {1'b0, 1'b1, 9'h000}, {1'b0, 1'b1, 9'h000},
    {1'b1, 1'b1, 9'h1AA}, {1'b0, 1'b1, 9'h000}, {1'b0, 1'b0, 9'h000}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             masterReset = 1'b1;
  logic             shiftIn = 1'b0, shiftOut = 1'b0, outputEnable = 1'b1;
  logic [WIDTH-1:0] dataIn = '0;
  logic             inReady, outReady, edgeFlag, halfFlag;
  logic [WIDTH-1:0] dataOut;

  shfifo u_shfifo (
    .clk(clk), .masterReset(masterReset), .shiftIn(shiftIn), .dataIn(dataIn),
    .inReady(inReady), .shiftOut(shiftOut), .outReady(outReady), .dataOut(dataOut),
    .outputEnable(outputEnable), .edgeFlag(edgeFlag), .halfFlag(halfFlag)
  );

  // chained pair for depth
  logic             upShiftIn = 1'b0, dnShiftOut = 1'b0;
  logic [WIDTH-1:0] upDataIn = '0;
  logic             upInReady, upOutReady, dnInReady, dnOutReady;
  logic             upEdge, upHalf, dnEdge, dnHalf;
  logic [WIDTH-1:0] upDataOut, dnDataOut;

  shfifo u_shfifo_up (
    .clk(clk), .masterReset(masterReset), .shiftIn(upShiftIn), .dataIn(upDataIn),
    .inReady(upInReady), .shiftOut(dnInReady), .outReady(upOutReady), .dataOut(upDataOut),
    .outputEnable(1'b1), .edgeFlag(upEdge), .halfFlag(upHalf)
  );
  shfifo u_shfifo_dn (
    .clk(clk), .masterReset(masterReset), .shiftIn(upOutReady), .dataIn(upDataOut),
    .inReady(dnInReady), .shiftOut(dnShiftOut), .outReady(dnOutReady), .dataOut(dnDataOut),
    .outputEnable(1'b1), .edgeFlag(dnEdge), .halfFlag(dnHalf)
  );

  int errors = 0;
  int checks = 0;
  logic [WIDTH-1:0] model [DEPTH];
  int head = 0;
  int cnt  = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    logic [WIDTH-1:0] expData;
    expData = (outputEnable && cnt > 0) ? model[head] : '0;
    check("R4 inReady", 32'(inReady), 32'(cnt < DEPTH));
    check("R4 outReady", 32'(outReady), 32'(cnt > 0));
    check("R5 edgeFlag", 32'(edgeFlag), 32'((cnt <= 8) || (cnt >= 56)));
    check("R6 halfFlag", 32'(halfFlag), 32'(cnt >= 32));
    check(cnt > 0 ? "R1 dataOut" : "R10 dataOut", 32'(dataOut), 32'(expData));
  endtask

  // called at a negedge; returns at the next negedge with the model updated
  task automatic step(input logic si, input logic so, input logic [WIDTH-1:0] d);
    logic wrOk, rdOk;
    shiftIn = si; shiftOut = so; dataIn = d;
    wrOk = si && (cnt < DEPTH);
    rdOk = so && (cnt > 0);
    @(negedge clk);
    if (wrOk) model[(head + cnt) % DEPTH] = d;
    if (rdOk) begin head = (head + 1) % DEPTH; cnt--; end
    if (wrOk) cnt++;
    shiftIn = 1'b0; shiftOut = 1'b0;
  endtask

  task automatic doReset();
    masterReset = 1'b1;
    #3;
    head = 0; cnt = 0;
    @(negedge clk);
    masterReset = 1'b0;
    @(negedge clk);
  endtask

  bit done = 1'b0;
  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    doReset();
    // R7 reset state
    check("R7 inReady", 32'(inReady), 32'd1);
    check("R7 outReady", 32'(outReady), 32'd0);
    check("R7 edgeFlag", 32'(edgeFlag), 32'd1);
    check("R7 halfFlag", 32'(halfFlag), 32'd0);
    check("R7 dataOut", 32'(dataOut), 32'd0);

    // vector table: ordering, R9 simultaneous strobes, R3 empty read
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][10], VEC[i][9], VEC[i][8:0]);
      checkAll();
    end

    // fill through all flag bands (R1 R2 R5 R6)
    doReset();
    for (int i = 0; i < DEPTH - 1; i++) begin
      step(1'b1, 1'b0, 9'((i * 37 + 5) % 512));
      checkAll();
    end
    // R12: flags move only at the edge
    shiftIn = 1'b1; dataIn = 9'h1C3;
    #1;
    check("R12 inReady before edge", 32'(inReady), 32'd1);
    shiftIn = 1'b0;
    step(1'b1, 1'b0, 9'h1C3);
    check("R12 inReady after edge", 32'(inReady), 32'd0);
    checkAll();
    // R2: writes at full are ignored
    step(1'b1, 1'b0, 9'h0EE);
    checkAll();
    // R8: output disabled
    outputEnable = 1'b0;
    #1;
    check("R8 disabled dataOut", 32'(dataOut), 32'd0);
    outputEnable = 1'b1;
    #1;
    check("R8 enabled dataOut", 32'(dataOut), 32'(model[head]));
    // R9: both strobes at full, only the read acts
    step(1'b1, 1'b1, 9'h0DD);
    check("R9 full both count", 32'(cnt), 32'd63);
    checkAll();
    // R9: mid occupancy both strobes
    step(1'b1, 1'b1, 9'h0BB);
    check("R9 mid both outReady", 32'(outReady), 32'd1);
    checkAll();
    // drain in order through all bands (R1)
    while (cnt > 0) begin
      step(1'b0, 1'b1, '0);
      checkAll();
    end
    // R3: read when empty ignored
    step(1'b0, 1'b1, '0);
    checkAll();

    // R7: reset with content
    step(1'b1, 1'b0, 9'h077);
    step(1'b1, 1'b0, 9'h078);
    doReset();
    check("R7 reset outReady", 32'(outReady), 32'd0);
    check("R7 reset dataOut", 32'(dataOut), 32'd0);
    checkAll();

    // R11: chained pair
    for (int i = 0; i < 100; i++) begin
      check("R11 upstream ready", 32'(upInReady), 32'd1);
      upShiftIn = 1'b1; upDataIn = 9'((i * 11 + 3) % 512);
      @(negedge clk);
      upShiftIn = 1'b0;
    end
    repeat (4) @(negedge clk);
    check("R11 downstream full", 32'(dnInReady), 32'd0);
    check("R11 upstream holds rest", 32'(upOutReady), 32'd1);
    for (int i = 0; i < 100; i++) begin
      check("R11 chained order", 32'(dnDataOut), 32'((i * 11 + 3) % 512));
      dnShiftOut = 1'b1;
      @(negedge clk);
      dnShiftOut = 1'b0;
      @(negedge clk);
    end
    check("R11 chain empty", 32'(dnOutReady), 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule